// File: doc/BRIEF.md
# Presettable BCD Up/Down Decade Counter

This block is one decimal digit of a counter. It holds a 4-bit BCD value and steps it by one on each rising clock edge. An active-low enable allows or blocks the step, and a direction input selects up or down. An active-low preset input overrides everything else. While it is held LOW, the digit shows the 4-bit data input at once, with no clock edge needed.

For chaining digits, the block decodes a terminal-count flag from the state and the direction. It also gates an active-low ripple-clock output from that flag, the enable and the clock. A higher digit can then take its clock or its enable from a lower one. Keep the data input steady while a preset pulse ends. The value held after release is the one the data input had at the last falling edge of the preset input or at the last rising clock edge during the preset.

Top module: `bcd_updown_digit`

## Requirements
- R1: While `load_n` is LOW, `q` equals `din` immediately, without any clock edge.
- R2: A rising clock edge while `load_n` is LOW has no counting effect: `q` stays equal to `din`.
- R3: A rising edge with `cnt_en_n` HIGH leaves `q` unchanged.
- R4: With `dir_up`=1 and `cnt_en_n` LOW, each rising edge moves `q` from n to n+1 for n in 0..8, and from 9 to 0.
- R5: With `dir_up`=0 and `cnt_en_n` LOW, each rising edge moves `q` from n to n-1 for n in 1..9, and from 0 to 9.
- R6: After a preset places a code from 10 to 15 in `q`, the next up step gives 0 and the next down step gives 9. `term_cnt` stays LOW for these codes.
- R7: `term_cnt` is HIGH exactly when (`dir_up`=1 and `q`=9) or (`dir_up`=0 and `q`=0). It follows a change of `dir_up` without a clock edge and does not depend on `cnt_en_n`.
- R8: `ripple_n` is LOW exactly when `term_cnt` is HIGH, `cnt_en_n` is LOW and `clk` is LOW. It is HIGH otherwise, so `cnt_en_n` HIGH suppresses the pulse.
- R9: `dir_up` may change only while `cnt_en_n` or `clk` is HIGH. `cnt_en_n` may rise only while `clk` is HIGH. Simulation flags any violation of either rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising-edge active |
| load_n | input | 1 | Asynchronous preset, active LOW |
| cnt_en_n | input | 1 | Count enable, active LOW |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | 4 | Preset value |
| q | output | 4 | Current digit |
| term_cnt | output | 1 | Terminal-count flag, active HIGH |
| ripple_n | output | 1 | Ripple clock for cascading, active LOW |

## Verification
- **Counting:** a count step appears on `q` after the first rising edge that follows the inputs enabling it, with one register in the path.
- **Immediate results:** the preset value, `term_cnt` and `ripple_n` need no edge, and a change of direction or enable reaches them at once.
- **Stimulus timing:** the bench drives every input 1 ns after a rising edge, while the clock is HIGH, so the control rules of R9 are always met.
- **Sampling points:** combinational results are checked 0.2 ns after each drive. Registered results, together with the LOW-phase ripple pulse, are checked 1 ns after the following falling edge. The bench model advances only at the rising edge, from the inputs held through the preceding cycle.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_TOP  = DIGIT_W'(9);
  localparam logic [DIGIT_W-1:0] DIGIT_ZERO = '0;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Next state for one count step; codes above the top wrap like an end value.
  function automatic digit_t bcd_step(input digit_t cur, input logic up);
    digit_t nxt;
    if (up) nxt = (cur >= DIGIT_TOP) ? DIGIT_ZERO : cur + DIGIT_W'(1);
    else    nxt = (cur == DIGIT_ZERO || cur > DIGIT_TOP) ? DIGIT_TOP : cur - DIGIT_W'(1);
    return nxt;
  endfunction

  // End-of-range decode for the selected direction.
  function automatic logic bcd_at_end(input digit_t cur, input logic up);
    return up ? (cur == DIGIT_TOP) : (cur == DIGIT_ZERO);
  endfunction
endpackage

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
  import bcd_digit_pkg::*;
(
  input  logic   clk,
  input  logic   load_n,
  input  logic   step_en,
  input  logic   dir_up,
  input  digit_t din,
  output digit_t q
);
  digit_t state_r;

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)      state_r <= din;
    else if (step_en) state_r <= bcd_step(state_r, dir_up);
  end

  // Preset is transparent while held so the data shows without an edge.
  assign q = load_n ? state_r : din;
endmodule

// File: rtl/bcd_term_decode.sv
module bcd_term_decode
  import bcd_digit_pkg::*;
(
  input  digit_t q,
  input  logic   dir_up,
  output logic   term_cnt
);
  assign term_cnt = bcd_at_end(q, dir_up);
endmodule

// File: rtl/bcd_ripple_gate.sv
module bcd_ripple_gate (
  input  logic clk,
  input  logic term_cnt,
  input  logic cnt_en_n,
  output logic ripple_n
);
  logic pass_clk;
  assign pass_clk = term_cnt & ~cnt_en_n;
  assign ripple_n = ~(pass_clk & ~clk);
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit
  import bcd_digit_pkg::*;
(
  input  logic               clk,
  input  logic               load_n,
  input  logic               cnt_en_n,
  input  logic               dir_up,
  input  logic [DIGIT_W-1:0] din,
  output logic [DIGIT_W-1:0] q,
  output logic               term_cnt,
  output logic               ripple_n
);
  logic   count_fire;
  logic   term_hit;
  digit_t q_int;

  assign count_fire = ~cnt_en_n;

  bcd_state_reg u_state (
    .clk     (clk),
    .load_n  (load_n),
    .step_en (count_fire),
    .dir_up  (dir_up),
    .din     (din),
    .q       (q_int)
  );

  bcd_term_decode u_term (
    .q        (q_int),
    .dir_up   (dir_up),
    .term_cnt (term_hit)
  );

  bcd_ripple_gate u_ripple (
    .clk      (clk),
    .term_cnt (term_hit),
    .cnt_en_n (cnt_en_n),
    .ripple_n (ripple_n)
  );

  assign q        = q_int;
  assign term_cnt = term_hit;
endmodule

// File: rtl/bcd_updown_digit_chk.sv
module bcd_updown_digit_chk (
  input logic       clk,
  input logic       load_n,
  input logic       cnt_en_n,
  input logic       dir_up,
  input logic [3:0] din,
  input logic [3:0] q,
  input logic       term_cnt,
  input logic       ripple_n
);
  AST_PRESET_SHOWN: assert property (@(negedge clk) disable iff (load_n) q == din); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!load_n)
    cnt_en_n |=> $stable(q)); // R3

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && dir_up && q < 4'd9) |=> q == $past(q) + 4'd1); // R4

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && dir_up && q >= 4'd9) |=> q == 4'd0); // R6

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !dir_up && q != 4'd0 && q <= 4'd9) |=> q == $past(q) - 4'd1); // R5

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !dir_up && (q == 4'd0 || q > 4'd9)) |=> q == 4'd9); // R5

  AST_TC_ONLY_ENDS: assert property (@(posedge clk) disable iff (!load_n)
    term_cnt |-> (q == 4'd9 || q == 4'd0)); // R7

  AST_TC_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!load_n)
    (q > 4'd9) |-> !term_cnt); // R6

  AST_RC_QUIET: assert property (@(posedge clk) disable iff (!load_n)
    cnt_en_n |-> ripple_n); // R8

  AST_RC_PULSE: assert property (@(posedge clk) disable iff (!load_n)
    (term_cnt && !cnt_en_n) |-> !ripple_n); // R8

  always @(dir_up) begin
    if (load_n === 1'b1)
      AST_DIR_SAFE: assert (cnt_en_n || clk); // R9
  end

  always @(posedge cnt_en_n) begin
    if (load_n === 1'b1)
      AST_EN_RISE: assert (clk); // R9
  end
endmodule

bind bcd_updown_digit bcd_updown_digit_chk u_chk (
  .clk      (clk),
  .load_n   (load_n),
  .cnt_en_n (cnt_en_n),
  .dir_up   (dir_up),
  .din      (din),
  .q        (q),
  .term_cnt (term_cnt),
  .ripple_n (ripple_n)
);

// File: tb/bcd_updown_digit_tb.sv
module bcd_updown_digit_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       load_n = 1'b0;
  logic       cnt_en_n = 1'b1;
  logic       dir_up = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] q;
  logic       term_cnt;
  logic       ripple_n;

  int         n_tests = 0;
  int         n_fail  = 0;
  logic [3:0] mdl = 4'd0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bcd_updown_digit u_dut (
    .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .dir_up(dir_up),
    .din(din), .q(q), .term_cnt(term_cnt), .ripple_n(ripple_n)
  );

  function automatic logic [3:0] exp_next(input logic [3:0] s, input logic up);
    if (up) begin
      if (s < 4'd9) return s + 4'd1;
      return 4'd0;
    end
    if (s >= 4'd1 && s <= 4'd9) return s - 4'd1;
    return 4'd9;
  endfunction

  function automatic logic exp_tc(input logic [3:0] s, input logic up);
    if (up && s == 4'd9) return 1'b1;
    if (!up && s == 4'd0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string qtag, input bit clk_low);
    logic tc_e;
    tc_e = exp_tc(mdl, dir_up);
    chk(q === mdl, qtag, "q", int'(q), int'(mdl));
    chk(term_cnt === tc_e, "R7", "term_cnt", int'(term_cnt), int'(tc_e));
    if (clk_low)
      chk(ripple_n === ~(tc_e & ~cnt_en_n), "R8", "ripple_n low phase",
          int'(ripple_n), int'(~(tc_e & ~cnt_en_n)));
    else
      chk(ripple_n === 1'b1, "R8", "ripple_n high phase", int'(ripple_n), 1);
  endtask

  // One cycle: model the rising edge, drive while clk HIGH, check both phases.
  task automatic step(input logic l, input logic e, input logic u,
                      input logic [3:0] d, input string qtag);
    @(posedge clk);
    if (!load_n)        mdl = din;
    else if (!cnt_en_n) mdl = exp_next(mdl, dir_up);
    #1;
    chk(clk === 1'b1, "R9", "drive inside clk high phase", int'(clk), 1);
    load_n = l; cnt_en_n = e; dir_up = u; din = d;
    if (!l) mdl = d;
    #0.2;
    check_all(qtag, 1'b0);
    @(negedge clk);
    #1;
    check_all(qtag, 1'b1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    #3;
    chk(q === 4'd0, "R1", "reset preset q", int'(q), 0);
    chk(ripple_n === 1'b1, "R8", "reset ripple_n", int'(ripple_n), 1);
    step(1'b0, 1'b1, 1'b1, 4'd0, "R1");

    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b1, 4'd0, "R4");
    for (int i = 0; i < 3; i++)  step(1'b1, 1'b1, 1'b1, 4'd0, "R3");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0, 4'd0, "R5");

    // Terminal count with enable held off: flag high, ripple stays high.
    step(1'b0, 1'b1, 1'b1, 4'd9, "R1");
    step(1'b1, 1'b1, 1'b1, 4'd9, "R3");
    step(1'b1, 1'b1, 1'b0, 4'd9, "R7");
    step(1'b1, 1'b1, 1'b1, 4'd9, "R7");

    // Preset held across edges with enable on.
    step(1'b0, 1'b0, 1'b1, 4'd5, "R2");
    step(1'b0, 1'b0, 1'b1, 4'd5, "R2");
    step(1'b1, 1'b0, 1'b1, 4'd5, "R2");
    step(1'b1, 1'b1, 1'b1, 4'd5, "R4");

    // Non-BCD codes.
    step(1'b0, 1'b0, 1'b1, 4'd12, "R6");
    step(1'b1, 1'b0, 1'b1, 4'd12, "R6");
    step(1'b1, 1'b1, 1'b1, 4'd0, "R6");
    step(1'b0, 1'b0, 1'b0, 4'd15, "R6");
    step(1'b1, 1'b0, 1'b0, 4'd15, "R6");
    step(1'b1, 1'b1, 1'b0, 4'd0, "R6");

    // Preset taken during the clock LOW phase, seen without an edge.
    @(negedge clk);
    #0.5;
    din = 4'd3; load_n = 1'b0; mdl = 4'd3;
    #0.2;
    chk(q === 4'd3, "R1", "async preset mid low phase", int'(q), 3);
    step(1'b1, 1'b0, 1'b1, 4'd3, "R1");

    for (int i = 0; i < 3000; i++) begin
      logic l, e, u;
      logic [3:0] d;
      l = (($urandom % 16) != 0);
      e = (($urandom % 4) == 0);
      u = 1'($urandom % 2);
      d = 4'($urandom % 16);
      step(l, e, u, d, "R4");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule